// File: doc/BRIEF.md
# Exclusive Two-Level Cache Controller

This block sits between a processor request port and a simple line-wide main-memory port. It holds two cache levels. The first is a small direct-mapped array that answers the fastest. The second is a 2-way set-associative array with the same number of sets, so it holds twice as many lines. The levels are kept exclusive: a line address is valid in at most one of them, so the total capacity is the sum of both arrays.

Every access probes the first level. On a first-level miss the second level is probed. A second-level hit exchanges the hit line with the first-level line at the same index. The displaced line drops into the slot that was just freed, and the request is then served from the first level. When both levels miss, the first-level line moves into the second level, taking an empty way or else the least-recently-used way. A dirty line evicted from that way is first written back to memory. The requested line is then read from memory straight into the first level. Dirty state moves with a line wherever it goes.

The controller handles one request at a time. The states are `ST_IDLE`, `ST_L1CHK`, `ST_L2CHK`, `ST_SWAP`, `ST_WBACK`, `ST_PUSH`, `ST_FILL` and `ST_DONE`. The transitions are:
- IDLE→L1CHK when a request is accepted.
- L1CHK→DONE on a first-level hit.
- L1CHK→L2CHK on a first-level miss.
- L2CHK→SWAP on a second-level hit.
- L2CHK→FILL on a miss when the first-level slot is empty.
- L2CHK→WBACK on a miss when the chosen second-level way holds a dirty valid line.
- L2CHK→PUSH on any other miss.
- SWAP→L1CHK always.
- WBACK→PUSH on the memory acknowledge.
- PUSH→FILL always.
- FILL→L1CHK on the memory acknowledge.
- DONE→IDLE always.

Top module: `excl_cache`

## Requirements
- R1: After reset `req_ready` is 1 and `resp_valid` and `mem_req` are 0. A request is accepted only while `req_ready` is high, and `req_ready` is low in the cycle after an acceptance.
- R2: A first-level hit raises `resp_valid` on the second rising edge after the accepting edge.
- R3: A second-level hit exchanges the line with the first-level line at that index and responds on the fifth rising edge after acceptance. An immediate repeat access to the same line is a first-level hit.
- R4: No line address is valid in both levels at once, and no line address is valid in two ways of one set.
- R5: When both levels miss, one line read is issued with `mem_line` = `req_addr[15:2]`. The line is installed in the first level, and `resp_valid` rises two edges after the read's acknowledge.
- R6: A valid first-level line displaced by a miss is kept in the second level, so its next access is a second-level hit.
- R7: A dirty second-level victim is written back with a line write, then one idle memory cycle follows, then the fill read. A clean victim is dropped with no memory write.
- R8: Dirty state travels with a line through exchanges and pushes, so data written earlier reaches memory when that line finally leaves the second level.
- R9: The second-level victim is the lowest-numbered empty way, otherwise the least-recently-used way. Recency is updated on every second-level hit and insertion.
- R10: Read data equals the most recent write to that word address, or the memory contents if the word was never written. The set index is `req_addr[5:2]` and the word within the line is `req_addr[1:0]`.
- R11: `resp_valid` is a single-cycle pulse, given exactly once for each accepted request, reads and writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_we | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read data, valid with `resp_valid` |
| mem_req | output | 1 | Memory line operation pending |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_line | output | 14 | Line address for memory |
| mem_wdata | output | 64 | Line written back, word 0 in the low bits |
| mem_rdata | input | 64 | Line read from memory, word 0 in the low bits |
| mem_ack | input | 1 | Memory completes the pending operation |

## Verification
The assertions check the following on every cycle:
- exclusivity between the levels at the addressed index, and uniqueness of hits within a set;
- the single-cycle response pulse and the loss of readiness after an acceptance;
- the write-back, idle cycle and fill-read ordering on the memory port;
- the fixed distance from a fill acknowledge to the response.

Only the bench's scenarios can show the rest: the exact latencies that separate a first-level hit from an exchange, the choice of the least-recently-used victim, and that data written long before survives several moves between levels and reaches memory only when its line finally leaves. Those scenarios also show that clean evictions cause no memory traffic.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int XC_WAYS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1CHK,
        ST_L2CHK,
        ST_SWAP,
        ST_WBACK,
        ST_PUSH,
        ST_FILL,
        ST_DONE
    } xc_state_e;
endpackage

// File: rtl/xc_l2_match.sv
module xc_l2_match
    import xc_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [TAG_W-1:0]                tag_i,
    input  logic [XC_WAYS-1:0]              valid_i,
    input  logic [XC_WAYS-1:0][TAG_W-1:0]   tags_i,
    input  logic                            lru_i,
    output logic                            hit_o,
    output logic                            hit_way_o,
    output logic                            vic_way_o
);
    logic [XC_WAYS-1:0] hit_vec;

    for (genvar w = 0; w < XC_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    assign hit_o     = |hit_vec;
    assign hit_way_o = hit_vec[1];
    // empty way first, lowest index first, otherwise the least recently used
    assign vic_way_o = !valid_i[0] ? 1'b0 : (!valid_i[1] ? 1'b1 : lru_i);

    AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)) else $error("line valid in two ways"); // R4
endmodule

// File: rtl/xc_word_port.sv
module xc_word_port #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 4
) (
    input  logic [WORDS*DATA_W-1:0]  line_i,
    input  logic [$clog2(WORDS)-1:0] off_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o,
    output logic [WORDS*DATA_W-1:0]  line_o
);
    localparam int OFF_W = $clog2(WORDS);

    assign rdata_o = line_i[off_i*DATA_W +: DATA_W];

    for (genvar w = 0; w < WORDS; w++) begin : g_merge
        assign line_o[w*DATA_W +: DATA_W] =
            (off_i == OFF_W'(w)) ? wdata_i : line_i[w*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/excl_cache.sv
module excl_cache
    import xc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WORDS  = 4,
    parameter int SETS   = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic                                   req_we,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    output logic                                   resp_valid,
    output logic [DATA_W-1:0]                      resp_rdata,
    output logic                                   mem_req,
    output logic                                   mem_we,
    output logic [ADDR_W-$clog2(WORDS)-1:0]        mem_line,
    output logic [WORDS*DATA_W-1:0]                mem_wdata,
    input  logic [WORDS*DATA_W-1:0]                mem_rdata,
    input  logic                                   mem_ack
);
    localparam int OFF_W   = $clog2(WORDS);
    localparam int IDX_W   = $clog2(SETS);
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int TAG_W   = LADDR_W - IDX_W;
    localparam int LINE_B  = WORDS * DATA_W;

    xc_state_e state, nxt;

    // captured request
    logic              r_we;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;

    // first level: direct mapped
    logic [LINE_B-1:0] l1_data [SETS];
    logic [TAG_W-1:0]  l1_tag  [SETS];
    logic [SETS-1:0]   l1_v, l1_d;

    // second level: XC_WAYS ways per set, one recency bit per set
    logic [XC_WAYS-1:0][LINE_B-1:0] l2_data [SETS];
    logic [XC_WAYS-1:0][TAG_W-1:0]  l2_tag  [SETS];
    logic [SETS-1:0][XC_WAYS-1:0]   l2_v, l2_d;
    logic [SETS-1:0]                l2_lru;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] rtag;
    logic [OFF_W-1:0] off;
    logic             l1_hit, l2_hit, hw, vw;
    logic [LINE_B-1:0] merged;
    logic [DATA_W-1:0] rd_word;

    assign idx    = r_addr[OFF_W +: IDX_W];
    assign rtag   = r_addr[ADDR_W-1 -: TAG_W];
    assign off    = r_addr[OFF_W-1:0];
    assign l1_hit = l1_v[idx] && (l1_tag[idx] == rtag);

    xc_l2_match #(.TAG_W(TAG_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tag_i     (rtag),
        .valid_i   (l2_v[idx]),
        .tags_i    (l2_tag[idx]),
        .lru_i     (l2_lru[idx]),
        .hit_o     (l2_hit),
        .hit_way_o (hw),
        .vic_way_o (vw)
    );

    xc_word_port #(.DATA_W(DATA_W), .WORDS(WORDS)) u_word (
        .line_i  (l1_data[idx]),
        .off_i   (off),
        .wdata_i (r_wdata),
        .rdata_o (rd_word),
        .line_o  (merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_L1CHK;
            ST_L1CHK: nxt = l1_hit ? ST_DONE : ST_L2CHK;
            ST_L2CHK: begin
                if (l2_hit)                           nxt = ST_SWAP;
                else if (!l1_v[idx])                  nxt = ST_FILL;
                else if (l2_v[idx][vw] && l2_d[idx][vw]) nxt = ST_WBACK;
                else                                  nxt = ST_PUSH;
            end
            ST_SWAP:  nxt = ST_L1CHK;
            ST_WBACK: if (mem_ack) nxt = ST_PUSH;
            ST_PUSH:  nxt = ST_FILL;
            ST_FILL:  if (mem_ack) nxt = ST_L1CHK;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        resp_valid = (state == ST_DONE);
        resp_rdata = rd_word;
        mem_req    = (state == ST_WBACK) || (state == ST_FILL);
        mem_we     = (state == ST_WBACK);
        mem_line   = (state == ST_WBACK) ? {l2_tag[idx][vw], idx} : {rtag, idx};
        mem_wdata  = l2_data[idx][vw];
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_we    <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            r_we    <= req_we;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
        end
    end

    // line payload and tags (no reset needed)
    always_ff @(posedge clk) begin
        if (state == ST_SWAP) begin
            l1_data[idx]     <= l2_data[idx][hw];
            l1_tag[idx]      <= l2_tag[idx][hw];
            l2_data[idx][hw] <= l1_data[idx];
            l2_tag[idx][hw]  <= l1_tag[idx];
        end
        if (state == ST_PUSH) begin
            l2_data[idx][vw] <= l1_data[idx];
            l2_tag[idx][vw]  <= l1_tag[idx];
        end
        if (state == ST_FILL && mem_ack) begin
            l1_data[idx] <= mem_rdata;
            l1_tag[idx]  <= rtag;
        end
        if (state == ST_DONE && r_we) l1_data[idx] <= merged;
    end

    // valid, dirty and recency state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l1_v   <= '0;
            l1_d   <= '0;
            l2_v   <= '0;
            l2_d   <= '0;
            l2_lru <= '0;
        end else begin
            if (state == ST_SWAP) begin
                l1_v[idx]     <= 1'b1;
                l1_d[idx]     <= l2_d[idx][hw];
                l2_v[idx][hw] <= l1_v[idx];
                l2_d[idx][hw] <= l1_d[idx];
                l2_lru[idx]   <= ~hw;
            end
            if (state == ST_PUSH) begin
                l2_v[idx][vw] <= 1'b1;
                l2_d[idx][vw] <= l1_d[idx];
                l2_lru[idx]   <= ~vw;
                l1_v[idx]     <= 1'b0;
            end
            if (state == ST_FILL && mem_ack) begin
                l1_v[idx] <= 1'b1;
                l1_d[idx] <= 1'b0;
            end
            if (state == ST_DONE && r_we) l1_d[idx] <= 1'b1;
        end
    end

    for (genvar w = 0; w < XC_WAYS; w++) begin : g_excl
        AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(l1_v[idx] && l2_v[idx][w] && (l1_tag[idx] == l2_tag[idx][w])))
            else $error("line valid in both levels"); // R4
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready) else $error("accepted while busy"); // R1

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid) else $error("response longer than one cycle"); // R11

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> !mem_req ##1 (mem_req && !mem_we))
        else $error("write-back not followed by fill"); // R7

    AST_FILL_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |-> ##2 resp_valid)
        else $error("fill not served from first level"); // R5
endmodule

// File: tb/excl_cache_test.sv
module excl_cache_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        resp_valid;
    logic [15:0] resp_rdata;
    logic        mem_req, mem_we;
    logic [13:0] mem_line;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    excl_cache uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    typedef struct {
        logic        we;
        logic [15:0] exp;
        int          cls;   // 0 first-level hit, 1 exchange, 2 memory, -1 any
        int          start;
        string       rq;
    } item_t;

    item_t       sb_q[$];
    logic [15:0] ref_mem [int];
    logic [15:0] main_mem [int];
    int checks = 0, errors = 0, cyc = 0, wr_cnt = 0, n_req = 0, n_resp = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] init_val(int a);
        return 16'(a * 7) ^ 16'h5A3C;
    endfunction

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // driver: issues one request and pushes its expectation
    task automatic access(bit we, logic [15:0] a, logic [15:0] d, int cls, string rq);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
        it.we = we;
        it.exp = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(int'(a));
        it.cls = cls; it.start = cyc; it.rq = rq;
        if (we) ref_mem[int'(a)] = d;
        sb_q.push_back(it);
        n_req++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0 || !req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expectations as responses appear
    initial begin
        forever begin
            @(negedge clk);
            if (resp_valid) begin
                n_resp++;
                if (sb_q.size() == 0) begin
                    check(0, "R11", "unexpected response", 1, 0);
                end else begin
                    item_t it;
                    int lat;
                    it = sb_q.pop_front();
                    lat = cyc - it.start;
                    if (!it.we) check(resp_rdata == it.exp, it.rq, "read data", resp_rdata, it.exp);
                    if (it.cls == 0) check(lat == 2, it.rq, "first-level latency", lat, 2);
                    if (it.cls == 1) check(lat == 5, it.rq, "exchange latency", lat, 5);
                    if (it.cls == 2) check(lat > 5, it.rq, "memory latency above 5", lat, 6);
                end
            end
        end
    end

    // main memory model, line wide
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat (2) @(negedge clk);
                for (int w = 0; w < 4; w++) begin
                    int a;
                    a = int'(mem_line) * 4 + w;
                    if (mem_we) main_mem[a] = mem_wdata[w*16 +: 16];
                    else mem_rdata[w*16 +: 16] = main_mem.exists(a) ? main_mem[a] : init_val(a);
                end
                if (mem_we) wr_cnt++;
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] x;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
        rst_n = 1'b1;

        // set 0: lines A, B, C, D differ only in tag
        access(1, 16'h0040, 16'h1234, 2, "R5");   // A miss, becomes dirty
        access(0, 16'h0040, 16'h0000, 0, "R2");   // A first-level hit
        access(0, 16'h0080, 16'h0000, 2, "R5");   // B miss, A pushed
        access(0, 16'h00C0, 16'h0000, 2, "R6");   // C miss, B pushed
        access(0, 16'h0040, 16'h0000, 1, "R3");   // A exchanged with C
        access(0, 16'h0041, 16'h0000, 0, "R3");   // A now first level
        access(0, 16'h0100, 16'h0000, 2, "R9");   // D miss, A pushed, B (lru) dropped
        drain();
        check(wr_cnt == 0, "R7", "clean victim write count", wr_cnt, 0);
        access(0, 16'h00C2, 16'h0000, 1, "R9");   // C kept
        access(0, 16'h0081, 16'h0000, 2, "R9");   // B was the victim
        drain();
        check(wr_cnt == 1, "R7", "dirty victim write count", wr_cnt, 1);
        check(main_mem.exists(16'h0040) && main_mem[16'h0040] == 16'h1234, "R8",
              "written-back word", main_mem.exists(16'h0040) ? main_mem[16'h0040] : 0, 16'h1234);
        access(0, 16'h0040, 16'h0000, 2, "R10");  // A returns from memory
        access(0, 16'h00C0, 16'h0000, -1, "R6");  // C pushed by B's fill, still cached
        drain();

        // sweep every set with writes then reads
        for (int i = 0; i < 16; i++)
            access(1, 16'h2000 + 16'(i*4 + (i % 4)), 16'(i * 16'h0111), 2, "R10");
        for (int i = 0; i < 16; i++)
            access(0, 16'h2000 + 16'(i*4 + (i % 4)), 16'h0000, 0, "R2");

        // mixed traffic over many tags per set
        x = 16'hACE1;
        for (int i = 0; i < 80; i++) begin
            x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
            access(x[0], 16'h3000 + {6'd0, x[11:2]}, x ^ 16'h0F0F, -1, "R10");
        end
        drain();
        check(n_resp == n_req, "R11", "responses per request", n_resp, n_req);
        check(sb_q.size() == 0, "R11", "outstanding expectations", sb_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule